// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock

This block keeps wall-clock time and date in packed BCD: seconds, minutes, hours (24-hour), day of month, month, a two-digit year counted from 2000, and a weekday. It advances once per second from a 32 kHz tick enable. The number of ticks that make one second is a parameter. A byte-wide register bus reads and writes the time fields, six alarm fields, a run control bit, a status byte and an interrupt enable.

Firmware can set or read the time while the clock keeps running. A busy status bit rises one tick period before every seconds update and falls on the tick that applies it. Seeing busy low therefore guarantees at least one tick period free of carries. A bus write to a time field lands on the edge it is issued and takes priority over an increment on the same edge. When a seconds update produces a time equal to all six alarm fields, a sticky alarm flag is set. The interrupt output is that flag gated by an enable bit.

Top module: `bcd_rtc`

## Requirements
- R1: After synchronous reset, the registers hold these values: time 00:00:00, day 0x01, month 0x01, year 0x00, weekday 0, all alarm fields 0x00, run 0, interrupt enable 0, status 0x00. The outputs `irq` and `rdata` are 0.
- R2: Register map. Time fields sit at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 (seconds, minutes, hours, day, month, year), and weekday sits at 0x18. Alarm fields sit at 0x20 to 0x34 in the same order. Control is at 0x40, status at 0x44 and interrupt enable at 0x48. `rdata` shows, one clock after `addr` is presented, the register values from before that edge. Weekday reads with its upper nibble as zero. Any other address reads 0x00.
- R3: Each second update increments seconds in BCD. Seconds and minutes wrap from 0x59 to 0x00, and each wrap carries into the next field. Hours wrap from 0x23 to 0x00 and carry into the day. The year wraps from 0x99 to 0x00.
- R4: The day wraps to 0x01 after the month's last day. Months 04, 06, 09 and 11 have 30 days, and February has 29 days when year mod 4 is 0 and 28 otherwise. Month wraps from 0x12 to 0x01 and carries into the year. Weekday advances on each day change and wraps from 6 to 0.
- R5: While running, each `tick` advances a prescaler. On tick number TICKS_PER_SEC one second update is applied. Status bit 0 (busy) goes high on the tick before that update and low on the tick that applies it.
- R6: With control bit 0 cleared, `tick` has no effect: time does not advance, busy reads 0 and the prescaler restarts from zero. Setting the bit resumes counting.
- R7: A bus write to a time field becomes visible on the next read, even on an edge that also carries a second update. On such an edge the written field takes the written value and the other fields take their incremented values. Only the low four bits of a weekday write are stored.
- R8: On the clock after each second update, the six alarm fields are compared with the time. A full match sets status bit 6. The bit stays set until status is written with bit 6 = 1. If a clear and a new match fall on the same edge, the match wins.
- R9: `irq` is registered and equals (status bit 6 AND interrupt-enable bit 3) as they stood one clock earlier.
- R10: Writes to status bit 0 and to any bit of status other than bit 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 32 kHz tick enable |
| wr_en | input | 1 | Write strobe for the register bus |
| addr | input | 8 | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data of the register at `addr` |
| irq | output | 1 | Alarm interrupt, registered |

## Verification
Several starting dates run through the carry chain. 28 February in a leap year tells the 29-day rule apart from the 28-day rule. 28 February in a non-leap year checks the other branch. 31 December 99 exercises the carry through every field up to the year wrap. An alarm is set a few seconds ahead, first with the interrupt enabled and then with it disabled. This separates the sticky flag from the interrupt gate, and a write-one clear shows the clear path. A stretch with the run bit cleared confirms that ticks are ignored. A burst of seconds writes spanning several carries shows which source wins on a colliding edge. A status-only polling window checks that busy is one tick wide.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int          N_FIELDS     = 6;
  localparam int          FIELD_STRIDE = 4;
  localparam logic [7:0]  OFF_TIME     = 8'h00;
  localparam logic [7:0]  OFF_WDAY     = 8'h18;
  localparam logic [7:0]  OFF_ALM      = 8'h20;
  localparam logic [7:0]  OFF_CTRL     = 8'h40;
  localparam logic [7:0]  OFF_STAT     = 8'h44;
  localparam logic [7:0]  OFF_IE       = 8'h48;
  localparam int          CTRL_RUN_BIT = 0;
  localparam int          STAT_BSY_BIT = 0;
  localparam int          STAT_ALM_BIT = 6;
  localparam int          IE_ALM_BIT   = 3;

  // field index order: 0 sec, 1 min, 2 hour, 3 day, 4 month, 5 year
  function automatic logic [7:0] field_addr(input logic [7:0] base, input int idx);
    return base + 8'(idx * FIELD_STRIDE);
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return v + 8'd1;
  endfunction

  // year is a BCD offset from 2000; leap when the two-digit value is a multiple of 4
  function automatic logic leap_year(input logic [7:0] yr);
    if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    else        return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic busy,
  output logic step
);
  localparam int            CW   = $clog2(TICKS_PER_SEC);
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] PRE  = CW'(TICKS_PER_SEC - 2);

  logic [CW-1:0] cnt;

  assign step = run && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (tick) begin
      if (cnt == LAST) begin
        cnt  <= '0;
        busy <= 1'b0;
      end else begin
        cnt  <= cnt + 1'b1;
        busy <= (cnt == PRE);
      end
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step,
  input  logic                     wr_en,
  input  logic [7:0]               addr,
  input  logic [7:0]               wdata,
  output logic [N_FIELDS-1:0][7:0] tnow,
  output logic [3:0]               wday,
  output logic                     updated
);
  logic [N_FIELDS-1:0][7:0] tnext;
  logic [N_FIELDS-1:0]      wsel;
  logic [3:0]               wday_next;
  logic c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    c_min = step  && (tnow[0] >= 8'h59);
    c_hr  = c_min && (tnow[1] >= 8'h59);
    c_day = c_hr  && (tnow[2] >= 8'h23);
    c_mon = c_day && (tnow[3] >= month_len(tnow[4], tnow[5]));
    c_yr  = c_mon && (tnow[4] >= 8'h12);

    tnext[0] = step  ? (c_min ? 8'h00 : bcd_inc(tnow[0])) : tnow[0];
    tnext[1] = c_min ? (c_hr  ? 8'h00 : bcd_inc(tnow[1])) : tnow[1];
    tnext[2] = c_hr  ? (c_day ? 8'h00 : bcd_inc(tnow[2])) : tnow[2];
    tnext[3] = c_day ? (c_mon ? 8'h01 : bcd_inc(tnow[3])) : tnow[3];
    tnext[4] = c_mon ? (c_yr  ? 8'h01 : bcd_inc(tnow[4])) : tnow[4];
    tnext[5] = c_yr  ? ((tnow[5] >= 8'h99) ? 8'h00 : bcd_inc(tnow[5])) : tnow[5];
    wday_next = c_day ? ((wday >= 4'd6) ? 4'd0 : wday + 4'd1) : wday;
  end

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
    localparam logic [7:0] RST_VAL = (i == 3 || i == 4) ? 8'h01 : 8'h00;
    assign wsel[i] = wr_en && (addr == field_addr(OFF_TIME, i));
    always_ff @(posedge clk) begin
      if (rst)          tnow[i] <= RST_VAL;
      else if (wsel[i]) tnow[i] <= wdata;
      else              tnow[i] <= tnext[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wday    <= 4'd0;
      updated <= 1'b0;
    end else begin
      updated <= step;
      if (wr_en && addr == OFF_WDAY) wday <= wdata[3:0];
      else                           wday <= wday_next;
    end
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [7:0]               addr,
  input  logic [7:0]               wdata,
  input  logic [N_FIELDS-1:0][7:0] tnow,
  input  logic                     updated,
  input  logic                     ie,
  output logic [N_FIELDS-1:0][7:0] alm,
  output logic                     flag,
  output logic                     irq
);
  logic [N_FIELDS-1:0] eq;
  logic                clr;

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_alm
    assign eq[i] = (alm[i] == tnow[i]);
    always_ff @(posedge clk) begin
      if (rst)                                          alm[i] <= 8'h00;
      else if (wr_en && addr == field_addr(OFF_ALM, i)) alm[i] <= wdata;
    end
  end

  assign clr = wr_en && (addr == OFF_STAT) && wdata[STAT_ALM_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= flag && ie;
      if (updated && (&eq)) flag <= 1'b1;
      else if (clr)         flag <= 1'b0;
    end
  end
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);
  logic                     run_q, ie_q, busy, step, updated, alarm_flag;
  logic [N_FIELDS-1:0][7:0] tnow, alm;
  logic [3:0]               wday;
  logic [7:0]               sec_byte, rd_next;

  assign sec_byte = tnow[0];

  rtc_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst(rst), .run(run_q), .tick(tick), .busy(busy), .step(step)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst(rst), .step(step), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .tnow(tnow), .wday(wday), .updated(updated)
  );

  rtc_alarm u_alm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .tnow(tnow),
    .updated(updated), .ie(ie_q), .alm(alm), .flag(alarm_flag), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      ie_q  <= 1'b0;
    end else if (wr_en) begin
      if (addr == OFF_CTRL) run_q <= wdata[CTRL_RUN_BIT];
      if (addr == OFF_IE)   ie_q  <= wdata[IE_ALM_BIT];
    end
  end

  always_comb begin
    rd_next = 8'h00;
    for (int i = 0; i < N_FIELDS; i++) begin
      if (addr == field_addr(OFF_TIME, i)) rd_next = tnow[i];
      if (addr == field_addr(OFF_ALM, i))  rd_next = alm[i];
    end
    if (addr == OFF_WDAY) rd_next = {4'h0, wday};
    if (addr == OFF_CTRL) rd_next[CTRL_RUN_BIT] = run_q;
    if (addr == OFF_STAT) begin
      rd_next[STAT_BSY_BIT] = busy;
      rd_next[STAT_ALM_BIT] = alarm_flag;
    end
    if (addr == OFF_IE) rd_next[IE_ALM_BIT] = ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= 8'h00;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/rtc_checks.sv
module rtc_checks (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       run,
  input logic       busy,
  input logic       wr_en,
  input logic [7:0] addr,
  input logic [7:0] wdata,
  input logic       ie,
  input logic       flag,
  input logic       irq,
  input logic [7:0] sec
);
  // R5: a tick while busy is the carry tick, so busy drops
  a_r5_busy_one_tick: assert property (@(posedge clk) disable iff (rst)
    (run && tick && busy) |=> !busy);

  // R5: busy only rises on a tick
  a_r5_busy_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(tick));

  // R6: stopped clock keeps busy low
  a_r6_stopped_no_busy: assert property (@(posedge clk) disable iff (rst)
    !run |=> !busy);

  // R6: stopped clock keeps seconds unless written
  a_r6_stopped_holds: assert property (@(posedge clk) disable iff (rst)
    (!run && !(wr_en && addr == 8'h00)) |=> $stable(sec));

  // R8: alarm flag is sticky until a write-one clear
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !(wr_en && addr == 8'h44 && wdata[6])) |=> flag);

  // R9: no interrupt without enable
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !ie |=> !irq);
endmodule

bind bcd_rtc rtc_checks u_chk (
  .clk(clk), .rst(rst), .tick(tick), .run(run_q), .busy(busy), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .ie(ie_q), .flag(alarm_flag), .irq(irq), .sec(sec_byte)
);

// File: tb/sim_bcd_rtc.sv
`timescale 1ns/1ps
module sim_bcd_rtc;
  localparam int TPS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic irq;

  always #2 clk = ~clk;

  bcd_rtc #(.TICKS_PER_SEC(TPS)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  bit tick_on = 1'b0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  int m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_wd, m_cnt;
  int m_al [6];
  bit m_run, m_ie, m_flag, m_pend, m_busy, m_carry, m_match, m_nflag;
  int exp_rd;
  bit exp_irq;

  function automatic int tobcd(int v); return ((v / 10) << 4) | (v % 10); endfunction
  function automatic int frombcd(int v); return ((v >> 4) * 10) + (v & 15); endfunction
  function automatic int mdays(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int rd_model(logic [7:0] a);
    case (a)
      8'h00: return tobcd(m_sec);
      8'h04: return tobcd(m_min);
      8'h08: return tobcd(m_hr);
      8'h0C: return tobcd(m_day);
      8'h10: return tobcd(m_mon);
      8'h14: return tobcd(m_yr);
      8'h18: return m_wd & 15;
      8'h20: return m_al[0];
      8'h24: return m_al[1];
      8'h28: return m_al[2];
      8'h2C: return m_al[3];
      8'h30: return m_al[4];
      8'h34: return m_al[5];
      8'h40: return int'(m_run);
      8'h44: return (int'(m_flag) << 6) | int'(m_busy);
      8'h48: return int'(m_ie) << 3;
      default: return 0;
    endcase
  endfunction

  task automatic advance();
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0;
    m_wd = (m_wd >= 6) ? 0 : m_wd + 1;
    if (m_day >= mdays(m_mon, m_yr)) begin
      m_day = 1;
      if (m_mon >= 12) begin
        m_mon = 1;
        m_yr = (m_yr >= 99) ? 0 : m_yr + 1;
      end else m_mon++;
    end else m_day++;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1; m_yr = 0; m_wd = 0;
      for (int i = 0; i < 6; i++) m_al[i] = 0;
      m_run = 0; m_ie = 0; m_flag = 0; m_pend = 0; m_busy = 0; m_cnt = 0;
      exp_rd = 0; exp_irq = 0;
    end else begin
      exp_rd  = rd_model(addr);
      exp_irq = m_flag && m_ie;
      m_match = (tobcd(m_sec) == m_al[0]) && (tobcd(m_min) == m_al[1]) &&
                (tobcd(m_hr) == m_al[2]) && (tobcd(m_day) == m_al[3]) &&
                (tobcd(m_mon) == m_al[4]) && (tobcd(m_yr) == m_al[5]);
      m_nflag = m_flag;
      if (wr_en && addr == 8'h44 && wdata[6]) m_nflag = 0;
      if (m_pend && m_match) m_nflag = 1;
      m_carry = 0;
      if (!m_run) begin
        m_cnt = 0; m_busy = 0;
      end else if (tick) begin
        if (m_cnt == TPS - 1) begin
          m_cnt = 0; m_busy = 0; m_carry = 1;
        end else begin
          m_busy = (m_cnt == TPS - 2);
          m_cnt++;
        end
      end
      m_pend = m_carry;
      m_flag = m_nflag;
      if (m_carry) advance();
      if (wr_en) begin
        case (addr)
          8'h00: m_sec = frombcd(wdata);
          8'h04: m_min = frombcd(wdata);
          8'h08: m_hr  = frombcd(wdata);
          8'h0C: m_day = frombcd(wdata);
          8'h10: m_mon = frombcd(wdata);
          8'h14: m_yr  = frombcd(wdata);
          8'h18: m_wd  = wdata & 15;
          8'h20: m_al[0] = wdata;
          8'h24: m_al[1] = wdata;
          8'h28: m_al[2] = wdata;
          8'h2C: m_al[3] = wdata;
          8'h30: m_al[4] = wdata;
          8'h34: m_al[5] = wdata;
          8'h40: m_run = wdata[0];
          8'h48: m_ie  = wdata[3];
          default: ;
        endcase
      end
    end
  end

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // compare outputs on every clock, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (cmp_on && !done) begin
        check(rdata == exp_rd[7:0], "rdata", int'(rdata), exp_rd);
        check(irq == exp_irq, "irq", int'(irq), int'(exp_irq));
      end
    end
  end

  // tick enable: one cycle in every four
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div++;
      tick = tick_on && (div % 4 == 0);
    end
  end

  localparam int NRD = 20;
  logic [7:0] rd_list [NRD] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C,
                                8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h34, 8'h38, 8'h40,
                                8'h44, 8'h48, 8'h4C, 8'h02};
  int rd_idx = 0;

  task automatic cyc(logic [7:0] a, logic [7:0] d, logic w);
    @(negedge clk);
    addr = a; wdata = d; wr_en = w;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      cyc(rd_list[rd_idx], 8'h00, 1'b0);
      rd_idx = (rd_idx + 1) % NRD;
    end
  endtask

  task automatic set_time(int hr, int mn, int sc, int dy, int mo, int yr, int wd);
    cyc(8'h40, 8'h00, 1'b1);
    cyc(8'h08, 8'(hr), 1'b1);
    cyc(8'h04, 8'(mn), 1'b1);
    cyc(8'h00, 8'(sc), 1'b1);
    cyc(8'h0C, 8'(dy), 1'b1);
    cyc(8'h10, 8'(mo), 1'b1);
    cyc(8'h14, 8'(yr), 1'b1);
    cyc(8'h18, 8'(wd), 1'b1);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL %s watchdog expired actual=running expected=finished", cur_req);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;
    tick_on = 1'b1;
    // R1 reset state, R2 map and unused addresses, R6 stopped clock ignores ticks
    cur_req = "R1"; idle(NRD);
    cur_req = "R2"; idle(2 * NRD);
    cur_req = "R6"; idle(64);
    // R10 writes to busy and other status bits ignored
    cur_req = "R10"; cyc(8'h44, 8'hBF, 1'b1); cyc(8'h44, 8'h01, 1'b1); idle(10);
    // R3/R4 leap February, midnight rollover, weekday 6 -> 0
    cur_req = "R4";
    set_time(8'h23, 8'h59, 8'h50, 8'h28, 8'h02, 8'h24, 8'h06);
    cyc(8'h40, 8'h01, 1'b1); idle(32 * 14);
    // R4 non-leap February
    set_time(8'h23, 8'h59, 8'h55, 8'h28, 8'h02, 8'h23, 8'h03);
    cyc(8'h40, 8'h01, 1'b1); idle(32 * 8);
    // R3 full carry into year wrap
    cur_req = "R3";
    set_time(8'h23, 8'h59, 8'h55, 8'h31, 8'h12, 8'h99, 8'h02);
    cyc(8'h40, 8'h01, 1'b1); idle(32 * 8);
    // R8/R9 alarm with interrupt enabled
    cur_req = "R8";
    set_time(8'h10, 8'h20, 8'h30, 8'h15, 8'h06, 8'h24, 8'h01);
    cyc(8'h20, 8'h33, 1'b1); cyc(8'h24, 8'h20, 1'b1); cyc(8'h28, 8'h10, 1'b1);
    cyc(8'h2C, 8'h15, 1'b1); cyc(8'h30, 8'h06, 1'b1); cyc(8'h34, 8'h24, 1'b1);
    cyc(8'h48, 8'h08, 1'b1);
    cyc(8'h40, 8'h01, 1'b1); idle(32 * 6);
    cur_req = "R9"; cyc(8'h44, 8'h40, 1'b1); idle(20);
    // R9 interrupt gated off while flag still sets
    cyc(8'h48, 8'h00, 1'b1); cyc(8'h20, 8'h40, 1'b1); idle(32 * 8);
    cyc(8'h48, 8'h08, 1'b1); idle(8);
    cyc(8'h44, 8'h40, 1'b1); idle(8);
    // R6 stop holds the time
    cur_req = "R6"; cyc(8'h40, 8'h00, 1'b1); idle(200);
    cyc(8'h40, 8'h01, 1'b1); idle(40);
    // R7 writes colliding with carries
    cur_req = "R7";
    for (int i = 0; i < 80; i++) cyc(8'h00, 8'h10, 1'b1);
    for (int i = 0; i < 40; i++) cyc(8'h18, 8'hF5, 1'b1);
    idle(NRD);
    // R5 busy polled continuously
    cur_req = "R5";
    for (int i = 0; i < 100; i++) cyc(8'h44, 8'h00, 1'b0);
    idle(10);
    finish_run();
  end
endmodule